// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block is the timekeeping core of a real-time clock. A free-running divider on the oscillator clock produces one enable pulse per second. That pulse advances a chain of BCD counters:

- seconds, minutes and hours, with hours in 24-hour form;
- a weekday from 0 to 6;
- a day of the month, a month, and a two-digit year.

Month lengths are applied automatically. February gets 29 days when the year is a leap year. The leap decision is read straight from the BCD digits of the year: an odd tens digit makes the year a leap year when the units digit is 2 or 6, and an even tens digit does so when the units digit is 0, 4 or 8.

A serial host engine talks to the block through a parallel load. A load writes every field in one cycle. While the engine reshapes a time value, it asserts a hold input that freezes the seconds enable and clears the divider. The register set also holds two extra bits:

- A frequency-select bit, stored as bit 3 of the weekday field. It chooses whether the frequency output carries a 1 Hz square wave or the raw oscillator clock.
- A sticky low-supply flag. The supply level is sampled twice per second, and a low reading sets the flag.

Top module: `rtc_calendar_core`

## Requirements
- R1: After synchronous reset the fields read seconds 00, minutes 00, hours 00, weekday 0, day 01, month 01, year 00. The select bit and the low-supply flag both read 0.
- R2: The seconds field advances once every 2^DIV_BITS clocks. Seconds step from 59 to 00 and carry into minutes, and minutes step from 59 to 00 and carry into hours. All values are BCD.
- R3: Hours step from 23 to 00. That step advances the weekday and the day of the month.
- R4: The weekday field, bits [2:0] of `wday_o`, counts 0 to 6 and returns to 0 after 6.
- R5: Day 30 is the last day of months 04, 06, 09 and 11, and day 31 is the last day of the other months except 02. After the last day, the day becomes 01 and the month advances. Month 12 returns to 01 and advances the year, and year 99 returns to 00.
- R6: February ends on day 29 in a leap year and on day 28 otherwise. A year is a leap year when its tens digit is odd and its units digit is 2 or 6, or when its tens digit is even and its units digit is 0, 4 or 8.
- R7: A clock edge with `load_en` high copies every `ld_*` input into its field, and this takes priority over a seconds tick in that cycle.
- R8: Bit 3 of `wday_o` is the select bit, and it is loaded from bit 3 of `ld_wday`. When the bit is 1, `fout` follows the clock. When it is 0, `fout` is a 1 Hz square wave that goes high at the edge where seconds advance and stays high for the first half of the second.
- R9: While `hold_div` is high, no field advances and the divider is cleared. After release, seconds advance on the 2^DIV_BITS-th clock edge counted from the first edge with `hold_div` low.
- R10: `low_supply` is sampled only at the half-second and full-second points of the divider, which are the edges where its lower DIV_BITS-1 bits are all ones. A high sample sets `lowv_o`, and the flag stays set until a load writes `ld_lowv`. A high level between sample points has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_div | input | 1 | Freeze the seconds enable and clear the divider |
| low_supply | input | 1 | Supply comparator output, high when the supply is low |
| load_en | input | 1 | Parallel load strobe |
| ld_sec | input | 7 | BCD seconds to load |
| ld_min | input | 7 | BCD minutes to load |
| ld_hour | input | 6 | BCD hours to load |
| ld_wday | input | 4 | [2:0] weekday, [3] frequency select |
| ld_day | input | 6 | BCD day to load |
| ld_mon | input | 5 | BCD month to load |
| ld_year | input | 8 | BCD year to load |
| ld_lowv | input | 1 | Low-supply flag value to load |
| sec_o | output | 7 | BCD seconds |
| min_o | output | 7 | BCD minutes |
| hour_o | output | 6 | BCD hours |
| wday_o | output | 4 | [2:0] weekday, [3] frequency select |
| day_o | output | 6 | BCD day |
| mon_o | output | 5 | BCD month |
| year_o | output | 8 | BCD year |
| lowv_o | output | 1 | Sticky low-supply flag |
| fout | output | 1 | 1 Hz wave or raw clock |

## Verification
Every field and the flag are registered, so the effect of a load, a tick or a supply sample appears one clock edge after the edge that samples it. The 1 Hz level changes on that same edge. The selected raw clock passes through combinationally.

The bench drives its inputs on the falling edge. It runs a behavioural model on the rising edge, and it compares all outputs with that model on the following falling edge. To check the second-boundary behaviour, each directed case loads a value while the divider is held. It then counts exactly 2^DIV_BITS - 1 and 2^DIV_BITS edges after release, so the value is checked both just before and just after the tick.

// File: rtl/rtc_cal_pkg.sv
// Package: field widths and BCD/calendar helper functions shared by the
// calendar core. Assumes all stored values are legal BCD.
package rtc_cal_pkg;
    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int WDAY_W = 3;
    localparam int DAY_W  = 6;
    localparam int MON_W  = 5;
    localparam int YEAR_W = 8;

    // Next value of a two-digit BCD number (no wrap handling).
    function automatic logic [7:0] bcd2_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
        return v + 8'd1;
    endfunction

    // Leap decision taken directly from tens parity and units value.
    function automatic logic leap_year(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    // Last BCD day of a BCD month.
    function automatic logic [7:0] month_end(input logic [4:0] m, input logic leap);
        case (m)
            5'h02:                      return leap ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_divider.sv
// Divider: counts oscillator clocks and yields the once-per-second tick,
// the half-second supply sample strobe and the 1 Hz square wave.
// Assumes DIV_BITS >= 2. Hold clears the count and masks both strobes.
module rtc_divider #(
    parameter int DIV_BITS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick,
    output logic check,
    output logic pulse_1hz
);
    localparam int LOW_BITS = DIV_BITS - 1;

    logic [DIV_BITS-1:0] div_q;

    // Divider count: cleared on reset or hold, otherwise free running.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) div_q <= '0;
        else                div_q <= div_q + 1'b1;
    end

    assign tick      = !hold && (&div_q);
    assign check     = !hold && (&div_q[LOW_BITS-1:0]);
    assign pulse_1hz = ~div_q[DIV_BITS-1];

    assert_hold_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !tick);
    assert_wave_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> pulse_1hz);
endmodule

// File: rtl/rtc_bcd_wrap.sv
// Generic wrapping BCD counter from FIRST to LAST. Used for seconds,
// minutes, hours and weekday. Load has priority over increment.
// Assumes loaded values are legal BCD no larger than LAST.
module rtc_bcd_wrap
    import rtc_cal_pkg::*;
#(
    parameter int         W     = 7,
    parameter logic [7:0] FIRST = 8'h00,
    parameter logic [7:0] LAST  = 8'h59
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] value,
    output logic         carry
);
    logic [7:0] cur;
    assign cur   = 8'(value);
    assign carry = inc && (cur >= LAST);

    // Counter register: reset, load, or step with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    value <= W'(FIRST);
        else if (load) value <= ld_val;
        else if (inc)  value <= (cur >= LAST) ? W'(FIRST) : W'(bcd2_inc(cur));
    end

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !load) |=> (value == W'(FIRST)));
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(value));
endmodule

// File: rtl/rtc_date.sv
// Date counter: day of month, month and two-digit year in BCD, with
// month lengths and the leap-year decision. Advances when inc is high.
// Assumes loaded values are legal BCD.
module rtc_date
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              load,
    input  logic [DAY_W-1:0]  ld_day,
    input  logic [MON_W-1:0]  ld_mon,
    input  logic [YEAR_W-1:0] ld_year,
    output logic [DAY_W-1:0]  day,
    output logic [MON_W-1:0]  mon,
    output logic [YEAR_W-1:0] year
);
    logic       leap;
    logic [7:0] last_day;
    logic       day_wrap, mon_wrap;

    assign leap     = leap_year(year);
    assign last_day = month_end(mon, leap);
    assign day_wrap = 8'(day) >= last_day;
    assign mon_wrap = mon >= 5'h12;

    // Date registers: reset, load, or advance with month/year carries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            day  <= DAY_W'(8'h01);
            mon  <= MON_W'(8'h01);
            year <= '0;
        end else if (load) begin
            day  <= ld_day;
            mon  <= ld_mon;
            year <= ld_year;
        end else if (inc) begin
            if (day_wrap) begin
                day <= DAY_W'(8'h01);
                if (mon_wrap) begin
                    mon  <= MON_W'(8'h01);
                    year <= (year == 8'h99) ? 8'h00 : bcd2_inc(year);
                end else begin
                    mon <= MON_W'(bcd2_inc(8'(mon)));
                end
            end else begin
                day <= DAY_W'(bcd2_inc(8'(day)));
            end
        end
    end

    assert_leap_feb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && mon == 5'h02 && day == 6'h28 && leap) |=> (day == 6'h29));
    assert_feb_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && mon == 5'h02 && day == 6'h28 && !leap) |=> (mon == 5'h03 && day == 6'h01));
    assert_year_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && mon == 5'h12 && day == 6'h31 && year == 8'h99) |=> (year == 8'h00));
endmodule

// File: rtl/rtc_calendar_core.sv
// Calendar core top: divider, BCD time chain, date counter, frequency
// select bit, sticky low-supply flag and the frequency output mux.
// Assumes the host engine loads legal BCD values.
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int DIV_BITS = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_div,
    input  logic              low_supply,
    input  logic              load_en,
    input  logic [SEC_W-1:0]  ld_sec,
    input  logic [MIN_W-1:0]  ld_min,
    input  logic [HOUR_W-1:0] ld_hour,
    input  logic [WDAY_W:0]   ld_wday,
    input  logic [DAY_W-1:0]  ld_day,
    input  logic [MON_W-1:0]  ld_mon,
    input  logic [YEAR_W-1:0] ld_year,
    input  logic              ld_lowv,
    output logic [SEC_W-1:0]  sec_o,
    output logic [MIN_W-1:0]  min_o,
    output logic [HOUR_W-1:0] hour_o,
    output logic [WDAY_W:0]   wday_o,
    output logic [DAY_W-1:0]  day_o,
    output logic [MON_W-1:0]  mon_o,
    output logic [YEAR_W-1:0] year_o,
    output logic              lowv_o,
    output logic              fout
);
    logic tick, check, pulse_1hz;
    logic sec_cy, min_cy, hour_cy, wday_cy;
    logic [WDAY_W-1:0] wday;
    logic fsel, lowv;

    rtc_divider #(.DIV_BITS(DIV_BITS)) u_div (
        .clk(clk), .rst_n(rst_n), .hold(hold_div),
        .tick(tick), .check(check), .pulse_1hz(pulse_1hz)
    );

    rtc_bcd_wrap #(.W(SEC_W), .FIRST(8'h00), .LAST(8'h59)) u_sec (
        .clk(clk), .rst_n(rst_n), .inc(tick), .load(load_en),
        .ld_val(ld_sec), .value(sec_o), .carry(sec_cy)
    );
    rtc_bcd_wrap #(.W(MIN_W), .FIRST(8'h00), .LAST(8'h59)) u_min (
        .clk(clk), .rst_n(rst_n), .inc(sec_cy), .load(load_en),
        .ld_val(ld_min), .value(min_o), .carry(min_cy)
    );
    rtc_bcd_wrap #(.W(HOUR_W), .FIRST(8'h00), .LAST(8'h23)) u_hour (
        .clk(clk), .rst_n(rst_n), .inc(min_cy), .load(load_en),
        .ld_val(ld_hour), .value(hour_o), .carry(hour_cy)
    );
    rtc_bcd_wrap #(.W(WDAY_W), .FIRST(8'h00), .LAST(8'h06)) u_wday (
        .clk(clk), .rst_n(rst_n), .inc(hour_cy), .load(load_en),
        .ld_val(ld_wday[WDAY_W-1:0]), .value(wday), .carry(wday_cy)
    );

    rtc_date u_date (
        .clk(clk), .rst_n(rst_n), .inc(hour_cy), .load(load_en),
        .ld_day(ld_day), .ld_mon(ld_mon), .ld_year(ld_year),
        .day(day_o), .mon(mon_o), .year(year_o)
    );

    // Frequency-select bit: held in the top bit of the weekday field.
    always_ff @(posedge clk) begin
        if (!rst_n)       fsel <= 1'b0;
        else if (load_en) fsel <= ld_wday[WDAY_W];
    end

    // Low-supply flag: loadable, set by a high sample at a check point.
    always_ff @(posedge clk) begin
        if (!rst_n)                  lowv <= 1'b0;
        else if (check && low_supply) lowv <= 1'b1;
        else if (load_en)            lowv <= ld_lowv;
    end

    assign wday_o = {fsel, wday};
    assign lowv_o = lowv;
    assign fout   = fsel ? clk : pulse_1hz;

    assert_week_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wday_cy && !load_en) |=> (wday_o[WDAY_W-1:0] == '0));
    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (sec_o == $past(ld_sec) && year_o == $past(ld_year)));
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lowv && !load_en) |=> lowv);
    assert_midnight_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hour_cy && !load_en) |=> (hour_o == '0));
endmodule

// File: tb/rtc_calendar_core_test.sv
module rtc_calendar_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int DB = 4;
    localparam int P  = 1 << DB;

    logic clk = 1'b0;
    logic rst_n = 1'b0, hold_div = 1'b0, low_supply = 1'b0, load_en = 1'b0, ld_lowv = 1'b0;
    logic [6:0] ld_sec = '0, ld_min = '0;
    logic [5:0] ld_hour = '0, ld_day = 6'h01;
    logic [3:0] ld_wday = '0;
    logic [4:0] ld_mon = 5'h01;
    logic [7:0] ld_year = '0;
    logic [6:0] sec_o, min_o;
    logic [5:0] hour_o, day_o;
    logic [3:0] wday_o;
    logic [4:0] mon_o;
    logic [7:0] year_o;
    logic lowv_o, fout;

    int n_chk = 0, n_err = 0;
    bit started = 0;

    rtc_calendar_core #(.DIV_BITS(DB)) uut (
        .clk(clk), .rst_n(rst_n), .hold_div(hold_div), .low_supply(low_supply),
        .load_en(load_en), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
        .ld_wday(ld_wday), .ld_day(ld_day), .ld_mon(ld_mon), .ld_year(ld_year),
        .ld_lowv(ld_lowv), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
        .wday_o(wday_o), .day_o(day_o), .mon_o(mon_o), .year_o(year_o),
        .lowv_o(lowv_o), .fout(fout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int tobcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction
    function automatic int frombcd(input int v);
        return (v >> 4) * 10 + (v & 15);
    endfunction
    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, decimal integers.
    int m_cnt, m_sec, m_min, m_hour, m_wd, m_day, m_mon, m_year;
    bit m_fsel, m_lowv;
    always @(posedge clk) begin
        bit tk, ck;
        if (!rst_n) begin
            m_cnt = 0; m_sec = 0; m_min = 0; m_hour = 0; m_wd = 0;
            m_day = 1; m_mon = 1; m_year = 0; m_fsel = 0; m_lowv = 0;
        end else begin
            tk = 0; ck = 0;
            if (hold_div) m_cnt = 0;
            else begin
                tk = (m_cnt == P - 1);
                ck = (m_cnt % (P / 2)) == (P / 2 - 1);
                m_cnt = (m_cnt + 1) % P;
            end
            if (load_en) m_lowv = ld_lowv;
            if (ck && low_supply) m_lowv = 1;
            if (load_en) begin
                m_sec = frombcd(ld_sec); m_min = frombcd(ld_min); m_hour = frombcd(ld_hour);
                m_wd = ld_wday[2:0]; m_fsel = ld_wday[3];
                m_day = frombcd(ld_day); m_mon = frombcd(ld_mon); m_year = frombcd(ld_year);
            end else if (tk) begin
                m_sec++;
                if (m_sec == 60) begin
                    m_sec = 0; m_min++;
                    if (m_min == 60) begin
                        m_min = 0; m_hour++;
                        if (m_hour == 24) begin
                            m_hour = 0; m_wd = (m_wd + 1) % 7; m_day++;
                            if (m_day > mdays(m_mon, m_year)) begin
                                m_day = 1; m_mon++;
                                if (m_mon == 13) begin m_mon = 1; m_year = (m_year + 1) % 100; end
                            end
                        end
                    end
                end
            end
        end
        started = 1;
    end

    // Per-cycle comparison on the falling edge.
    always @(negedge clk) begin
        if (started) begin
            chk("R2 seconds", int'(sec_o), tobcd(m_sec));
            chk("R2 minutes", int'(min_o), tobcd(m_min));
            chk("R3 hours", int'(hour_o), tobcd(m_hour));
            chk("R4 weekday", int'(wday_o[2:0]), m_wd);
            chk("R5 day", int'(day_o), tobcd(m_day));
            chk("R5 month", int'(mon_o), tobcd(m_mon));
            chk("R5 year", int'(year_o), tobcd(m_year));
            chk("R8 select bit", int'(wday_o[3]), int'(m_fsel));
            chk("R8 fout", int'(fout), m_fsel ? 0 : int'(m_cnt < P / 2));
            chk("R10 flag", int'(lowv_o), int'(m_lowv));
        end
    end

    // Load a value with the divider held, then release it.
    task automatic load_held(input int s, input int mi, input int h, input int wd,
                             input int d, input int mo, input int y);
        @(negedge clk);
        hold_div = 1; load_en = 1;
        ld_sec = 7'(tobcd(s)); ld_min = 7'(tobcd(mi)); ld_hour = 6'(tobcd(h));
        ld_wday = 4'(wd); ld_day = 6'(tobcd(d)); ld_mon = 5'(tobcd(mo)); ld_year = 8'(tobcd(y));
        @(negedge clk);
        load_en = 0;
        @(negedge clk);
        hold_div = 0;
    endtask

    task automatic one_sec();
        repeat (P) @(negedge clk);
    endtask

    task automatic feb(input int y, input int exp_mon, input int exp_day);
        load_held(59, 59, 23, 0, 28, 2, y);
        one_sec();
        chk("R6 leap month", int'(mon_o), tobcd(exp_mon));
        chk("R6 leap day", int'(day_o), tobcd(exp_day));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 seconds", int'(sec_o), 0);
        chk("R1 day", int'(day_o), 1);
        chk("R1 month", int'(mon_o), 1);
        chk("R1 select", int'(wday_o[3]), 0);
        chk("R1 flag", int'(lowv_o), 0);
        rst_n = 1;
        repeat (3 * P) @(negedge clk);

        // R3 R4 R5 full rollover at year end, weekday 6
        load_held(59, 59, 23, 6, 31, 12, 99);
        repeat (P - 1) @(negedge clk);
        chk("R9 no tick before a full second", int'(sec_o), 8'h59);
        @(negedge clk);
        chk("R3 hour wrap", int'(hour_o), 0);
        chk("R4 weekday wrap", int'(wday_o[2:0]), 0);
        chk("R5 year wrap", int'(year_o), 0);
        chk("R5 month wrap", int'(mon_o), 1);

        // R5 month lengths
        load_held(59, 59, 23, 2, 30, 4, 21);
        one_sec();
        chk("R5 30-day month", int'(mon_o), 5'h05);
        load_held(59, 59, 23, 2, 30, 1, 21);
        one_sec();
        chk("R5 31-day month keeps day 31", int'(day_o), 6'h31);

        // R6 leap rule from digits
        feb(24, 2, 29); feb(23, 3, 1); feb(96, 2, 29); feb(10, 3, 1);
        feb(0, 2, 29);  feb(12, 2, 29); feb(14, 3, 1);

        // R2 minutes carry over a run
        load_held(50, 58, 10, 3, 15, 6, 40);
        repeat (15) one_sec();
        chk("R2 minute carry", int'(min_o), 7'h59);

        // R9 hold freezes fields
        @(negedge clk); hold_div = 1;
        repeat (3 * P) @(negedge clk);
        chk("R9 frozen during hold", int'(sec_o), 7'h05);
        hold_div = 0;
        repeat (P - 1) @(negedge clk);
        chk("R9 not yet after release", int'(sec_o), 7'h05);
        @(negedge clk);
        chk("R9 advance after release", int'(sec_o), 7'h06);

        // R7 load mid-second
        @(negedge clk);
        load_en = 1; ld_sec = 7'h42; ld_wday = 4'h5;
        @(negedge clk);
        load_en = 0;
        chk("R7 load seconds", int'(sec_o), 7'h42);

        // R8 select raw clock
        @(negedge clk);
        load_en = 1; ld_wday = 4'hB;
        @(negedge clk);
        load_en = 0;
        chk("R8 select bit loaded", int'(wday_o), 4'hB);
        @(posedge clk); #1;
        chk("R8 fout high with clock", int'(fout), 1);
        @(negedge clk); #1;
        chk("R8 fout low with clock", int'(fout), 0);
        load_held(0, 0, 0, 0, 1, 1, 0);

        // R10 off-point pulse ignored, sustained level sets flag, load clears
        @(negedge clk); @(negedge clk);
        low_supply = 1;
        @(negedge clk);
        low_supply = 0;
        @(negedge clk);
        chk("R10 off-point sample ignored", int'(lowv_o), 0);
        low_supply = 1;
        one_sec();
        low_supply = 0;
        chk("R10 flag set", int'(lowv_o), 1);
        repeat (P) @(negedge clk);
        chk("R10 flag sticky", int'(lowv_o), 1);
        load_held(0, 0, 0, 0, 1, 1, 0);
        chk("R10 flag cleared by load", int'(lowv_o), 0);

        repeat (2 * P) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule